// File: doc/BRIEF.md
# Console Keyboard and Display Register Set

This block is a small peripheral on a 16-bit memory bus. It holds a status/data register pair for a keyboard and another pair for a character display, each register at a fixed address. Software polls the status words, or lets an interrupt request do the waiting.

On the keyboard side, a one-cycle strobe arrives with an 8-bit character code. The block latches the code and raises its ready flag. Until software reads the data word, the keyboard is locked and further strobes are dropped. On the display side, a write to the display data word hands the character to a built-in busy/done model of the output device. The display ready flag is low while the character is in progress.

Each status word carries a software-writable enable bit. Each device's interrupt request is its ready flag gated by its enable bit.

Top module: `console_regs`

## Requirements
- R1: Registers sit at 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) and 0xFE06 (display data). `busRdData` is combinational and follows the addressed register while `busRe` is high. It is zero when `busRe` is low or the address matches none of the four. Data words read back with bits [15:8] zero.
- R2: A `keyStrobe` while keyboard ready is 0 stores `keyChar` into keyboard data bits [7:0] and sets keyboard ready (status bit 15) from the next cycle.
- R3: A `keyStrobe` while keyboard ready is 1 is dropped, and the stored character stays unchanged.
- R4: A read of the keyboard data word clears keyboard ready from the next cycle, unless a strobe is accepted in the same cycle.
- R5: A write to the display data word while display ready is 1 stores bits [7:0] on `dispChar`. It pulses `dispStart` high for the next cycle and drops display ready.
- R6: A write to the display data word while display ready is 0 has no effect.
- R7: After an accepted display write, display ready reads 0 for exactly `BUSY_CYCLES` cycles and then returns to 1.
- R8: Bit 14 of each status word is a read/write enable bit. Status words read as {ready, enable, 14'b0}. Bus writes to bit 15 are ignored, and writes to the keyboard data word are ignored.
- R9: `kbdIrq` is high exactly when keyboard ready and its enable are both 1. `dispIrq` is high exactly when display ready and its enable are both 1.
- R10: `droppedKeys` counts dropped strobes and saturates at its all-ones value.
- R11: After reset, keyboard ready is 0, both enables are 0, display ready is 1, `droppedKeys` is 0 and `dispStart` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus address |
| busWrData | input | 16 | Bus write data |
| busWe | input | 1 | Bus write enable |
| busRe | input | 1 | Bus read enable |
| busRdData | output | 16 | Bus read data |
| keyStrobe | input | 1 | One-cycle keystroke strobe |
| keyChar | input | 8 | Character code with the strobe |
| dispChar | output | 8 | Character handed to the display |
| dispStart | output | 1 | One-cycle pulse when a character is handed over |
| kbdIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |
| droppedKeys | output | DROP_W | Saturating count of dropped keystrokes |

## Verification
The ready flags and the busy counter are internal state that shows up at the ports. It appears in the status read data and in the interrupt lines within one clock of the event that should move it. A stuck or mistimed keyboard ready therefore appears on the very next status poll as a wrong bit 15, a wrongly accepted or dropped character, or a spurious `droppedKeys` step. A busy counter that is off by one shows a display ready edge one cycle early or late, and a second display write then gets accepted or rejected wrongly. The bench compares every port to a behavioural model on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/console_pkg.sv
`timescale 1ns/1ps
package console_pkg;

  // Read-data source selected by the control for the datapath mux.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } rdSel_t;

  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic   keyLoad;   // accept keystroke into data register
    logic   keyDrop;   // keystroke arrived while locked
    logic   kieWr;     // write keyboard enable bit
    logic   dieWr;     // write display enable bit
    logic   dispLoad;  // accept character for display
    rdSel_t rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/console_ctrl.sv
`timescale 1ns/1ps
module console_ctrl
  import console_pkg::*;
#(
  parameter int AW          = 16,
  parameter int REG_BASE    = 16'hFE00,
  parameter int REG_STRIDE  = 2,
  parameter int BUSY_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic          keyStrobe,
  output ctrlStrobe_t   strobe,
  output logic          kbdReady,
  output logic          dispReady
);

  localparam int NUM_REGS = 4;
  localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);
  localparam int SLOT_KSTAT = 0;
  localparam int SLOT_KDATA = 1;
  localparam int SLOT_DSTAT = 2;
  localparam int SLOT_DDATA = 3;

  logic [NUM_REGS-1:0] hit;
  logic [CNT_W-1:0]    busyLeft;
  logic                kbdRead;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_decode
    assign hit[i] = (busAddr == AW'(REG_BASE + i * REG_STRIDE));
  end

  assign kbdRead = busRe & hit[SLOT_KDATA];

  always_comb begin
    strobe.keyLoad  = keyStrobe & ~kbdReady;
    strobe.keyDrop  = keyStrobe & kbdReady;
    strobe.kieWr    = busWe & hit[SLOT_KSTAT];
    strobe.dieWr    = busWe & hit[SLOT_DSTAT];
    strobe.dispLoad = busWe & hit[SLOT_DDATA] & dispReady;
    strobe.rdSel    = SEL_NONE;
    if (busRe) begin
      if      (hit[SLOT_KSTAT]) strobe.rdSel = SEL_KSTAT;
      else if (hit[SLOT_KDATA]) strobe.rdSel = SEL_KDATA;
      else if (hit[SLOT_DSTAT]) strobe.rdSel = SEL_DSTAT;
      else if (hit[SLOT_DDATA]) strobe.rdSel = SEL_DDATA;
    end
  end

  // Keyboard lock: set on accepted key, cleared by data read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdReady <= 1'b0;
    end else if (strobe.keyLoad) begin
      kbdReady <= 1'b1;
    end else if (kbdRead) begin
      kbdReady <= 1'b0;
    end
  end

  // Display sink model: busy for BUSY_CYCLES cycles after a load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispReady <= 1'b1;
      busyLeft  <= '0;
    end else if (strobe.dispLoad) begin
      dispReady <= 1'b0;
      busyLeft  <= CNT_W'(BUSY_CYCLES);
    end else if (!dispReady) begin
      if (busyLeft == CNT_W'(1)) begin
        dispReady <= 1'b1;
        busyLeft  <= '0;
      end else begin
        busyLeft  <= busyLeft - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/console_dp.sv
`timescale 1ns/1ps
module console_dp
  import console_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CW     = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              kbdReady,
  input  logic              dispReady,
  input  logic [CW-1:0]     keyChar,
  input  logic [DW-1:0]     busWrData,
  output logic [DW-1:0]     busRdData,
  output logic              kbdIrq,
  output logic              dispIrq,
  output logic [CW-1:0]     dispChar,
  output logic              dispStart,
  output logic [DROP_W-1:0] droppedKeys
);

  localparam int IE_BIT  = DW - 2;
  localparam int PAD_W   = DW - 2;
  localparam int EXT_W   = DW - CW;

  logic [CW-1:0]     kbdData;
  logic [CW-1:0]     dispData;
  logic              kbdIe;
  logic              dispIe;
  logic [DROP_W-1:0] dropCnt;
  logic              unusedWrBits;

  assign unusedWrBits = ^{busWrData[DW-1], busWrData[DW-3:CW]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdData <= '0;
    end else if (strobe.keyLoad) begin
      kbdData <= keyChar;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispData  <= '0;
      dispStart <= 1'b0;
    end else begin
      dispStart <= strobe.dispLoad;
      if (strobe.dispLoad) dispData <= busWrData[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdIe  <= 1'b0;
      dispIe <= 1'b0;
    end else begin
      if (strobe.kieWr) kbdIe  <= busWrData[IE_BIT];
      if (strobe.dieWr) dispIe <= busWrData[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dropCnt <= '0;
    end else if (strobe.keyDrop && (dropCnt != '1)) begin
      dropCnt <= dropCnt + DROP_W'(1);
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_KSTAT: busRdData = {kbdReady, kbdIe, {PAD_W{1'b0}}};
      SEL_KDATA: busRdData = {{EXT_W{1'b0}}, kbdData};
      SEL_DSTAT: busRdData = {dispReady, dispIe, {PAD_W{1'b0}}};
      SEL_DDATA: busRdData = {{EXT_W{1'b0}}, dispData};
      default:   busRdData = '0;
    endcase
  end

  assign kbdIrq      = kbdReady & kbdIe;
  assign dispIrq     = dispReady & dispIe;
  assign dispChar    = dispData;
  assign droppedKeys = dropCnt;

endmodule

// File: rtl/console_regs.sv
`timescale 1ns/1ps
module console_regs
  import console_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CW          = 8,
  parameter int REG_BASE    = 16'hFE00,
  parameter int REG_STRIDE  = 2,
  parameter int BUSY_CYCLES = 4,
  parameter int DROP_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     busAddr,
  input  logic [DW-1:0]     busWrData,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DW-1:0]     busRdData,
  input  logic              keyStrobe,
  input  logic [CW-1:0]     keyChar,
  output logic [CW-1:0]     dispChar,
  output logic              dispStart,
  output logic              kbdIrq,
  output logic              dispIrq,
  output logic [DROP_W-1:0] droppedKeys
);

  ctrlStrobe_t strobe;
  logic        kbdReady;
  logic        dispReady;

  console_ctrl #(
    .AW(AW), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .keyStrobe(keyStrobe), .strobe(strobe),
    .kbdReady(kbdReady), .dispReady(dispReady)
  );

  console_dp #(
    .DW(DW), .CW(CW), .DROP_W(DROP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .kbdReady(kbdReady),
    .dispReady(dispReady), .keyChar(keyChar), .busWrData(busWrData),
    .busRdData(busRdData), .kbdIrq(kbdIrq), .dispIrq(dispIrq),
    .dispChar(dispChar), .dispStart(dispStart), .droppedKeys(droppedKeys)
  );

endmodule

// File: rtl/console_regs_chk.sv
`timescale 1ns/1ps
module console_regs_chk #(
  parameter int AW          = 16,
  parameter int REG_BASE    = 16'hFE00,
  parameter int REG_STRIDE  = 2,
  parameter int BUSY_CYCLES = 4,
  parameter int DROP_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [AW-1:0]     busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic              keyStrobe,
  input logic              kbdReady,
  input logic              dispReady,
  input logic              kbdIrq,
  input logic              dispIrq,
  input logic              dispStart,
  input logic [DROP_W-1:0] droppedKeys
);

  localparam logic [AW-1:0] KDATA_ADDR = AW'(REG_BASE + REG_STRIDE);
  localparam logic [AW-1:0] DDATA_ADDR = AW'(REG_BASE + 3 * REG_STRIDE);
  localparam int LOW_W = $clog2(BUSY_CYCLES + 2);

  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (dispReady) lowCnt <= '0;
    else if (lowCnt != '1) lowCnt <= lowCnt + LOW_W'(1);
  end

  p_key_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe && !kbdReady |=> kbdReady);

  p_key_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    kbdReady && !(busRe && busAddr == KDATA_ADDR) |=> kbdReady);

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    kbdReady && busRe && busAddr == KDATA_ADDR |=> !kbdReady);

  p_disp_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    dispReady && busWe && busAddr == DDATA_ADDR |=> !dispReady && dispStart);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dispReady |-> !dispStart || $past(dispReady));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_W'(BUSY_CYCLES));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dispReady && lowCnt == LOW_W'(BUSY_CYCLES - 1) && !dispStart |=> dispReady);

  p_kirq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !kbdReady |-> !kbdIrq);

  p_dirq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dispReady |-> !dispIrq);

  p_drop_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe && kbdReady && droppedKeys != '1
      |=> droppedKeys == $past(droppedKeys) + DROP_W'(1));

endmodule

bind console_regs console_regs_chk #(
  .AW(AW), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE),
  .BUSY_CYCLES(BUSY_CYCLES), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busRe(busRe), .keyStrobe(keyStrobe), .kbdReady(kbdReady),
  .dispReady(dispReady), .kbdIrq(kbdIrq), .dispIrq(dispIrq),
  .dispStart(dispStart), .droppedKeys(droppedKeys)
);

// File: tb/console_regs_tb.sv
`timescale 1ns/1ps
module console_regs_tb;

  localparam int BUSY  = 4;
  localparam int DROPW = 4;
  localparam int KSTAT = 'hFE00;
  localparam int KDATA = 'hFE02;
  localparam int DSTAT = 'hFE04;
  localparam int DDATA = 'hFE06;

  logic             clk = 1'b0;
  logic             rstN;
  logic [15:0]      busAddr, busWrData, busRdData;
  logic             busWe, busRe, keyStrobe;
  logic [7:0]       keyChar, dispChar;
  logic             dispStart, kbdIrq, dispIrq;
  logic [DROPW-1:0] droppedKeys;

  always #4 clk = ~clk;

  console_regs #(.BUSY_CYCLES(BUSY), .DROP_W(DROPW)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busRe(busRe), .busRdData(busRdData),
    .keyStrobe(keyStrobe), .keyChar(keyChar), .dispChar(dispChar),
    .dispStart(dispStart), .kbdIrq(kbdIrq), .dispIrq(dispIrq),
    .droppedKeys(droppedKeys)
  );

  int vectors = 0;
  int errors  = 0;

  // Behavioural model state
  int mKRdy, mKData, mKIe, mDRdy, mDData, mDIe, mBusy, mDrop, mStart;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRead(int a, int re);
    if (!re) return 0;
    case (a)
      KSTAT:   return mKRdy * 'h8000 + mKIe * 'h4000;
      KDATA:   return mKData;
      DSTAT:   return mDRdy * 'h8000 + mDIe * 'h4000;
      DDATA:   return mDData;
      default: return 0;
    endcase
  endfunction

  function automatic string readTag(int a, int re);
    if (!re) return "R1";
    case (a)
      KSTAT, DSTAT: return "R8";
      KDATA:        return "R2";
      DDATA:        return "R5";
      default:      return "R1";
    endcase
  endfunction

  task automatic modelReset();
    mKRdy = 0; mKData = 0; mKIe = 0; mDRdy = 1; mDData = 0;
    mDIe = 0; mBusy = 0; mDrop = 0; mStart = 0;
  endtask

  // One bus cycle: drive at negedge, compare, update model at posedge.
  task automatic cyc(string focus, int a, int wd, bit we, bit re, bit ks, int kc);
    busAddr = 16'(a); busWrData = 16'(wd); busWe = we; busRe = re;
    keyStrobe = ks; keyChar = 8'(kc);
    #1;
    chk((focus != "") ? focus : readTag(a, re), int'(busRdData), expRead(a, re));
    chk("R9 kbdIrq", int'(kbdIrq), mKRdy & mKIe);
    chk("R9 dispIrq", int'(dispIrq), mDRdy & mDIe);
    chk("R5 dispChar", int'(dispChar), mDData);
    chk("R5 dispStart", int'(dispStart), mStart);
    chk("R10 droppedKeys", int'(droppedKeys), mDrop);
    @(posedge clk);
    begin
      int wasKRdy = mKRdy;
      int dAcc = (we && a == DDATA && mDRdy) ? 1 : 0;
      if (ks && !wasKRdy) begin mKRdy = 1; mKData = kc & 'hFF; end
      else if (re && a == KDATA) mKRdy = 0;
      if (ks && wasKRdy && mDrop < (1 << DROPW) - 1) mDrop++;
      if (we && a == KSTAT) mKIe = (wd >> 14) & 1;
      if (we && a == DSTAT) mDIe = (wd >> 14) & 1;
      mStart = dAcc;
      if (dAcc) begin mDData = wd & 'hFF; mDRdy = 0; mBusy = BUSY; end
      else if (!mDRdy) begin
        mBusy--;
        if (mBusy == 0) mDRdy = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(string focus, int a);
    cyc(focus, a, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWrData = '0; busWe = 0; busRe = 0;
    keyStrobe = 0; keyChar = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    idle("R11", KSTAT);
    idle("R11", DSTAT);
    // R2 accept a key, R4 read clears ready
    cyc("R2", KSTAT, 0, 0, 1, 1, 'h41);
    idle("R2", KSTAT);
    idle("R2", KDATA);
    idle("R4", KSTAT);
    // R3 lockout
    cyc("R3", 0, 0, 0, 0, 1, 'h51);
    cyc("R3", 0, 0, 0, 0, 1, 'h52);
    idle("R3", KDATA);
    // R8 enable bits, bit 15 write ignored, keyboard data write ignored
    cyc("R8", KSTAT, 'hC000, 1, 0, 0, 0);
    idle("R8", KSTAT);
    cyc("R8", KDATA, 'h00EE, 1, 0, 0, 0);
    idle("R8", KDATA);
    cyc("R8", DSTAT, 'h4000, 1, 0, 0, 0);
    idle("R8", DSTAT);
    // R9 keyboard interrupt with enable set
    cyc("R9", 0, 0, 0, 0, 1, 'h33);
    idle("R9", KDATA);
    // R5 display load, R6 ignored while busy, R7 busy length
    cyc("R5", DDATA, 'h1278, 1, 0, 0, 0);
    cyc("R6", DDATA, 'h0079, 1, 0, 0, 0);
    idle("R6", DDATA);
    for (int i = 0; i < BUSY + 2; i++) idle("R7", DSTAT);
    // R10 saturation of drop counter
    cyc("R10", 0, 0, 0, 0, 1, 'h20);
    for (int i = 0; i < 20; i++) cyc("R10", 0, 0, 0, 0, 1, i);
    idle("R10", KDATA);
    // R1 unmapped, odd and disabled reads
    idle("R1", 'hFE08);
    idle("R1", 'hFE01);
    cyc("R1", KSTAT, 0, 0, 0, 0, 0);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 6);
      int a;
      case (sel)
        0: a = KSTAT; 1: a = KDATA; 2: a = DSTAT; 3: a = DDATA;
        4: a = KDATA; 5: a = 'hFE10; default: a = DDATA;
      endcase
      cyc("", a, int'($urandom_range(0, 'hFFFF)), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 1) == 1), ($urandom_range(0, 2) == 0),
          int'($urandom_range(0, 255)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule